// File: doc/BRIEF.md
# Radix-4 Add-Compare-Select Array with Wrap-Around Metrics

This block performs the state-metric update of a small radix-4 Viterbi trellis. Each update advances the trellis by two binary steps at once. For every state, a dedicated add-compare-select unit adds a two-step branch metric to each of the four predecessor metrics. It keeps the smallest of the four sums and reports, as a 2-bit decision, which predecessor produced it. The array holds the metrics in a registered bank. The bank is written on every accepted update. A synchronous load path places a supplied vector of starting metrics into the bank.

The metrics are never rescaled. Every sum is taken modulo 2^W by discarding the carry. Two metrics are ordered by the sign bit of their difference in W bits. This ordering is correct as long as the spread between any two live metrics stays below 2^(W-1). The trellis itself guarantees that bound, provided the bank starts from consistent values such as a steady-state profile. Branch metric generation and survivor storage belong to neighbouring blocks.

Top module: `r4_acs_array`

## Requirements
- R1: While `rst_n` is low at a clock edge, the bank is cleared after that edge: all metrics 0, all decisions 0 and `upd_valid` 0.
- R2: When `seed_load` is high at an edge, the bank takes `seed_metrics` after that edge, with state s in bits [s*MW +: MW]. `seed_load` wins over `step_valid`, and `upd_valid` is then 0.
- R3: When `step_valid` is high and `seed_load` is low, each state s becomes the minimum of four candidates. Candidate j (0..3) is the metric of predecessor p = j*(NS/4) + s/4 plus branch metric `branch_metrics[(s*4+j)*BMW +: BMW]`, zero-extended to MW bits.
- R4: For each state s, the decision field `decisions[2*s +: 2]` holds the binary index j of the winning candidate from the same update.
- R5: Sums wrap modulo 2^MW. Candidate a counts as smaller than b exactly when bit MW-1 of (a - b) mod 2^MW is 1, so an overflowed sum can still lose to a larger non-overflowed one.
- R6: Among equal smallest candidates, the one with the lowest index j wins.
- R7: With both `step_valid` and `seed_load` low, the metrics and decisions keep their values.
- R8: `upd_valid` is 1 in the cycle after an accepted update (R3) and 0 after any other edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| step_valid | input | 1 | Perform one radix-4 update this edge |
| seed_load | input | 1 | Load starting metrics this edge |
| seed_metrics | input | NS*MW | Starting metrics, state s at [s*MW +: MW] |
| branch_metrics | input | NS*4*BMW | Two-step branch metrics, state s, candidate j at [(s*4+j)*BMW +: BMW] |
| metrics | output | NS*MW | Registered state metrics |
| decisions | output | NS*2 | Registered 2-bit decisions, state s at [2*s +: 2] |
| upd_valid | output | 1 | Bank holds the result of an update |

## Verification
The bench targets sums that wrap. In its directed case the true minimum has not overflowed, while a wrapped candidate is numerically smaller. A design that used a plain unsigned compare would pick the wrong predecessor and report a tiny metric. Ties are driven across all four candidates and across the upper pair only; a tree that favoured the later operand would report decision 1 or 3 instead of 0 or 2. Other cases load seeds while an update is also requested, hold the bank between updates, and check that a mis-wired predecessor index shows up as wrong metrics over a long random run.

// File: rtl/r4_acs_pkg.sv
// Package: shared helpers for the radix-4 ACS array.
// Assumes metrics are unsigned values that wrap modulo 2^W.
package r4_acs_pkg;

    // Wrap-aware ordering: a is below b when (a - b) in W bits is negative.
    function automatic logic wrap_below(input logic [15:0] a, input logic [15:0] b,
                                        input int unsigned w);
        logic [15:0] diff;
        diff = a - b;
        return diff[w-1];
    endfunction

endpackage

// File: rtl/r4_wrap_cmp.sv
// Module: r4_wrap_cmp
// Purpose: decides whether metric a is smaller than metric b under wrap-around
// arithmetic. Assumes the true spread between a and b is below 2^(W-1).
module r4_wrap_cmp #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic         a_below
);
    logic [W-1:0] diff;

    // Difference taken in W bits; its sign bit gives the ordering.
    always_comb begin
        diff    = a - b;
        a_below = diff[W-1];
    end
endmodule

// File: rtl/r4_acs_unit.sv
// Module: r4_acs_unit
// Purpose: one radix-4 add-compare-select. It adds four branch metrics to four
// predecessor metrics, picks the smallest sum and returns it with its 2-bit index.
// Assumes the candidate spread is below 2^(W-1). Ties go to the lower index.
module r4_acs_unit
    import r4_acs_pkg::*;
#(
    parameter int W  = 8,
    parameter int BW = 5
) (
    input  logic [4*W-1:0]  pred_metrics,
    input  logic [4*BW-1:0] branch,
    output logic [W-1:0]    new_metric,
    output logic [1:0]      decision
);
    logic [W-1:0] cand [4];
    logic         pick1, pick3, pick_hi;
    logic [W-1:0] lo_win, hi_win;

    // Add stage: carries out of W bits are dropped on purpose.
    for (genvar j = 0; j < 4; j++) begin : g_add
        assign cand[j] = pred_metrics[j*W +: W] + W'(branch[j*BW +: BW]);
    end

    // First compare level: each pair keeps its lower index unless strictly beaten.
    r4_wrap_cmp #(.W(W)) u_cmp01 (.a(cand[1]), .b(cand[0]), .a_below(pick1));
    r4_wrap_cmp #(.W(W)) u_cmp23 (.a(cand[3]), .b(cand[2]), .a_below(pick3));

    // Pair winners are selected before the final compare.
    always_comb begin
        lo_win = pick1 ? cand[1] : cand[0];
        hi_win = pick3 ? cand[3] : cand[2];
    end

    // Final compare: the upper pair wins only when strictly smaller.
    r4_wrap_cmp #(.W(W)) u_cmp_fin (.a(hi_win), .b(lo_win), .a_below(pick_hi));

    // Decision encoding and 4:1 select of the surviving metric.
    always_comb begin
        decision   = pick_hi ? {1'b1, pick3} : {1'b0, pick1};
        new_metric = cand[decision];
    end

    // Guard: the chosen sum is not beaten by any candidate, and no lower
    // index holds the same value.
    always_comb begin
        for (int j = 0; j < 4; j++) begin
            assert_min_R3: assert (!wrap_below(16'(cand[j]), 16'(new_metric), W))
                else $error("candidate %0d below selected metric", j);
            assert_tie_low_R6: assert (!(j < int'(decision) && cand[j] == new_metric))
                else $error("lower index %0d ties the winner", j);
        end
    end
endmodule

// File: rtl/r4_acs_array.sv
// Module: r4_acs_array
// Purpose: radix-4 state-metric update for an NS-state trellis. One ACS unit per
// state feeds a registered metric bank, which also accepts a synchronous seed
// load. Assumes NS is a power of two of at least 4 and that the seeds are
// trellis-consistent, so every live metric spread stays below 2^(MW-1).
module r4_acs_array #(
    parameter int NS  = 8,
    parameter int MW  = 8,
    parameter int BMW = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                step_valid,
    input  logic                seed_load,
    input  logic [NS*MW-1:0]    seed_metrics,
    input  logic [NS*4*BMW-1:0] branch_metrics,
    output logic [NS*MW-1:0]    metrics,
    output logic [NS*2-1:0]     decisions,
    output logic                upd_valid
);
    localparam int GROUP = NS / 4;

    logic [MW-1:0] bank_q   [NS];
    logic [1:0]    dec_q    [NS];
    logic [MW-1:0] next_m   [NS];
    logic [1:0]    next_d   [NS];
    logic          accept;

    assign accept = step_valid && !seed_load;

    // One ACS per state; candidate j reads predecessor j*GROUP + s/4.
    for (genvar s = 0; s < NS; s++) begin : g_state
        logic [4*MW-1:0] preds;
        for (genvar j = 0; j < 4; j++) begin : g_pred
            assign preds[j*MW +: MW] = bank_q[j*GROUP + s/4];
        end
        r4_acs_unit #(.W(MW), .BW(BMW)) u_acs (
            .pred_metrics (preds),
            .branch       (branch_metrics[s*4*BMW +: 4*BMW]),
            .new_metric   (next_m[s]),
            .decision     (next_d[s])
        );
        assign metrics[s*MW +: MW] = bank_q[s];
        assign decisions[2*s +: 2] = dec_q[s];
    end

    // Bank register: reset, seed load, update or hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < NS; s++) begin
                bank_q[s] <= '0;
                dec_q[s]  <= '0;
            end
        end else if (seed_load) begin
            for (int s = 0; s < NS; s++) bank_q[s] <= seed_metrics[s*MW +: MW];
        end else if (step_valid) begin
            for (int s = 0; s < NS; s++) begin
                bank_q[s] <= next_m[s];
                dec_q[s]  <= next_d[s];
            end
        end
    end

    // Update flag: marks a bank that holds a fresh ACS result.
    always_ff @(posedge clk) begin
        if (!rst_n) upd_valid <= 1'b0;
        else        upd_valid <= accept;
    end

    assert_reset_R1: assert property (@(posedge clk)
        !rst_n |=> (metrics == '0 && decisions == '0 && !upd_valid));

    assert_seed_R2: assert property (@(posedge clk) disable iff (!rst_n)
        seed_load |=> (metrics == $past(seed_metrics) && !upd_valid));

    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!seed_load && !step_valid) |=> ($stable(metrics) && $stable(decisions)));

    assert_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (step_valid && !seed_load) |=> upd_valid);
endmodule

// File: tb/r4_acs_array_tb.sv
`timescale 1ns/1ps
module r4_acs_array_tb;
    localparam int NS  = 8;
    localparam int MW  = 8;
    localparam int BMW = 5;

    logic clk = 1'b0;
    logic rst_n, step_valid, seed_load;
    logic [NS*MW-1:0]    seed_metrics;
    logic [NS*4*BMW-1:0] branch_metrics;
    logic [NS*MW-1:0]    metrics;
    logic [NS*2-1:0]     decisions;
    logic                upd_valid;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    logic [MW-1:0] mdl_m [NS];
    logic [1:0]    mdl_d [NS];
    logic          mdl_v;

    always #10 clk = ~clk;

    r4_acs_array #(.NS(NS), .MW(MW), .BMW(BMW)) u_dut (
        .clk(clk), .rst_n(rst_n), .step_valid(step_valid), .seed_load(seed_load),
        .seed_metrics(seed_metrics), .branch_metrics(branch_metrics),
        .metrics(metrics), .decisions(decisions), .upd_valid(upd_valid)
    );

    function automatic logic below(input logic [MW-1:0] a, input logic [MW-1:0] b);
        logic [MW-1:0] d;
        d = a - b;
        return d[MW-1];
    endfunction

    // Reference update per R3..R6, applied after each edge.
    task automatic model_edge();
        logic [MW-1:0] nm [NS];
        logic [1:0]    nd [NS];
        if (!rst_n) begin
            for (int s = 0; s < NS; s++) begin mdl_m[s] = '0; mdl_d[s] = '0; end
            mdl_v = 0;
        end else if (seed_load) begin
            for (int s = 0; s < NS; s++) mdl_m[s] = seed_metrics[s*MW +: MW];
            mdl_v = 0;
        end else if (step_valid) begin
            for (int s = 0; s < NS; s++) begin
                logic [MW-1:0] best, c;
                best = '0; nd[s] = 2'd0;
                for (int j = 0; j < 4; j++) begin
                    c = mdl_m[j*(NS/4) + s/4] + MW'(branch_metrics[(s*4+j)*BMW +: BMW]);
                    if (j == 0 || below(c, best)) begin best = c; nd[s] = 2'(j); end
                end
                nm[s] = best;
            end
            for (int s = 0; s < NS; s++) begin mdl_m[s] = nm[s]; mdl_d[s] = nd[s]; end
            mdl_v = 1;
        end else begin
            mdl_v = 0;
        end
    endtask

    task automatic compare(input string tag);
        logic [NS*MW-1:0] em;
        logic [NS*2-1:0]  ed;
        for (int s = 0; s < NS; s++) begin
            em[s*MW +: MW] = mdl_m[s];
            ed[2*s +: 2]   = mdl_d[s];
        end
        n_cmp += 3;
        if (metrics !== em) begin
            n_bad++; $display("FAIL %s metrics actual %h expected %h", tag, metrics, em);
        end
        if (decisions !== ed) begin
            n_bad++; $display("FAIL %s decisions actual %h expected %h", tag, decisions, ed);
        end
        if (upd_valid !== mdl_v) begin
            n_bad++; $display("FAIL %s upd_valid actual %b expected %b", tag, upd_valid, mdl_v);
        end
    endtask

    // Drive inputs after a falling edge, let one rising edge pass, then check.
    task automatic cycle(input logic sv, input logic sl, input string tag);
        step_valid = sv; seed_load = sl;
        @(posedge clk);
        #1 model_edge();
        @(negedge clk);
        compare(tag);
    endtask

    task automatic fill_seeds(input logic [MW-1:0] base, input int spread);
        for (int s = 0; s < NS; s++)
            seed_metrics[s*MW +: MW] = base + MW'($urandom_range(spread));
    endtask

    task automatic set_all_bm(input logic [BMW-1:0] b0, input logic [BMW-1:0] b1,
                              input logic [BMW-1:0] b2, input logic [BMW-1:0] b3);
        for (int s = 0; s < NS; s++) begin
            branch_metrics[(s*4+0)*BMW +: BMW] = b0;
            branch_metrics[(s*4+1)*BMW +: BMW] = b1;
            branch_metrics[(s*4+2)*BMW +: BMW] = b2;
            branch_metrics[(s*4+3)*BMW +: BMW] = b3;
        end
    endtask

    task automatic rand_bm();
        for (int i = 0; i < NS*4; i++)
            branch_metrics[i*BMW +: BMW] = BMW'($urandom_range(28));
    endtask

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'd20240611);
        rst_n = 0; step_valid = 1; seed_load = 0;
        seed_metrics = '0; branch_metrics = '0;
        for (int s = 0; s < NS; s++) begin mdl_m[s] = 'x; mdl_d[s] = 'x; end
        mdl_v = 'x;
        @(negedge clk);
        cycle(1, 0, "R1 reset");
        rst_n = 1;

        // R2: seed load, then seed load competing with an update request.
        for (int s = 0; s < NS; s++) seed_metrics[s*MW +: MW] = MW'(10 * s + 3);
        cycle(0, 1, "R2 seed");
        rand_bm(); fill_seeds(8'd40, 30);
        cycle(1, 1, "R2 seed wins over step");

        // R6: every candidate equal -> decision 0.
        for (int s = 0; s < NS; s++) seed_metrics[s*MW +: MW] = 8'd5;
        cycle(0, 1, "R2 seed");
        set_all_bm(5'd3, 5'd3, 5'd3, 5'd3);
        cycle(1, 0, "R6 four-way tie");
        n_cmp++;
        if (decisions !== '0 || metrics[MW-1:0] !== 8'd8) begin
            n_bad++; $display("FAIL R6 tie actual %h/%h expected 0/08", decisions, metrics[MW-1:0]);
        end

        // R6: upper pair tied and smallest -> decision 2.
        for (int s = 0; s < NS; s++) seed_metrics[s*MW +: MW] = 8'd0;
        cycle(0, 1, "R2 seed");
        set_all_bm(5'd9, 5'd9, 5'd4, 5'd4);
        cycle(1, 0, "R6 upper-pair tie");
        n_cmp++;
        if (decisions[1:0] !== 2'd2) begin
            n_bad++; $display("FAIL R6 upper tie actual %0d expected 2", decisions[1:0]);
        end

        // R5: 250+7 wraps to 1, yet 250+0 is the true minimum -> decision 0, metric 250.
        for (int s = 0; s < NS; s++) seed_metrics[s*MW +: MW] = 8'd250;
        cycle(0, 1, "R2 seed");
        set_all_bm(5'd0, 5'd12, 5'd7, 5'd20);
        cycle(1, 0, "R5 wrap compare");
        n_cmp++;
        if (decisions[1:0] !== 2'd0 || metrics[MW-1:0] !== 8'd250) begin
            n_bad++; $display("FAIL R5 wrap actual %0d/%0d expected 0/250",
                              decisions[1:0], metrics[MW-1:0]);
        end

        // R7: hold with changing branch inputs.
        rand_bm(); cycle(0, 0, "R7 hold");
        rand_bm(); cycle(0, 0, "R7 hold");

        // R3/R4/R8: random run from a consistent start, with idle gaps.
        fill_seeds(8'd200, 20);
        cycle(0, 1, "R2 seed");
        for (int i = 0; i < 400; i++) begin
            rand_bm();
            if ($urandom_range(7) == 0) cycle(0, 0, "R7 idle gap");
            else                        cycle(1, 0, "R3 R4 R8 random step");
        end

        // R1: reset in the middle of a run.
        rst_n = 0;
        cycle(1, 0, "R1 mid-run reset");
        rst_n = 1;
        rand_bm(); cycle(1, 0, "R3 step from zero bank");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule